// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block guards a processor against runaway software. A counter advances once per pulse of a slow tick enable. If the counter reaches the overflow count picked by a 3-bit period select, the block raises a reset request for one system clock. Software prevents this by writing a fixed 8-bit key to a trigger port. The write only counts if it lands inside the refresh window, which is the last part of the period. A write with the wrong value, or a write that comes too early, raises the reset request at once.

Two low-power inputs, halt and stop, can freeze the count. A standby-run configuration bit decides whether they do. When the freeze ends, the count restarts from zero. An interval flag pulses at three quarters of the period, so the CPU knows when to refresh. The period select, window select and standby-run bit are static configuration inputs. Everything runs in one system clock domain with an asynchronous active-low reset, which is assumed to be released synchronously upstream.

Top module: `keyed_watchdog`

## Requirements
- R1: The overflow count in ticks is set by `period_sel`: 0→128, 1→256, 2→512, 3→1024, 4→4096, 5→16384, 6→32768, 7→131072.
- R2: On the tick edge that would bring the count to the overflow value, the count returns to zero. `rst_req` is then high for exactly the following cycle. Out of reset both outputs are low.
- R3: Writing `trig_data` = 0xAC with `trig_we` high while the window is open clears the count to zero, and no reset request follows.
- R4: With `standby_run` = 0, holding `halt_req` or `stop_req` high freezes the count. No overflow occurs for as long as the freeze lasts.
- R5: With `standby_run` = 1, `halt_req` and `stop_req` have no effect, and the count keeps advancing.
- R6: On the first cycle after a freeze ends, the count is cleared to zero. Any tick in that cycle is ignored, and counting then restarts.
- R7: A trigger write of any value other than 0xAC raises `rst_req` in the next cycle and clears the count.
- R8: The window opens when the count is at or above a start point, and a key write before that point is a violation that raises `rst_req`. The start point is set by `window_sel`: 0 means half the period, so start = period/2. 1 means 75% open, so start = period/4. 2 and 3 mean fully open, so start = 0.
- R9: `intv_irq` pulses for one cycle right after the tick edge that brings the count to 3/4 of the overflow value.
- R10: A valid key write on the same edge as an overflowing tick wins. The count clears and no reset request is raised.
- R11: The count advances only on cycles where `tick_en` is high. Nothing else can advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle slow-clock tick enable |
| period_sel | input | 3 | Overflow period select |
| window_sel | input | 2 | Refresh window size select |
| standby_run | input | 1 | 1: keep counting in halt/stop |
| halt_req | input | 1 | Halt power mode active |
| stop_req | input | 1 | Stop power mode active |
| trig_we | input | 1 | Trigger register write strobe |
| trig_data | input | 8 | Trigger write data |
| rst_req | output | 1 | One-cycle reset request |
| intv_irq | output | 1 | Three-quarter interval pulse |

## Verification
Refresh and overflow can land on the same edge. The bench provokes this by running exactly one tick short of the period and then driving a valid key write together with the final tick. It judges the outcome by the absence of `rst_req` and by the full period that follows before the next overflow. A second collision also gets attention: the wake-up clear arriving together with a tick. Here the bench measures the restarted period, which must be one cycle longer than the tick count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned WDG_SEL_W  = 3;
  localparam int unsigned WDG_WSEL_W = 2;
  localparam int unsigned WDG_DATA_W = 8;
  localparam logic [WDG_DATA_W-1:0] WDG_KEY = 8'hAC;

  typedef enum logic [WDG_WSEL_W-1:0] {
    WIN_HALF    = 2'd0,
    WIN_3QTR    = 2'd1,
    WIN_FULL    = 2'd2,
    WIN_FULL_B  = 2'd3
  } win_sel_e;

  // log2 of the overflow count for each period select code
  function automatic int unsigned period_exp(input logic [WDG_SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 7;
      3'd1:    return 8;
      3'd2:    return 9;
      3'd3:    return 10;
      3'd4:    return 12;
      3'd5:    return 14;
      3'd6:    return 15;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/wdg_limits.sv
module wdg_limits
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic [WDG_SEL_W-1:0]  period_sel,
  input  logic [WDG_WSEL_W-1:0] window_sel,
  output logic [CNT_W-1:0]      limit,
  output logic [CNT_W-1:0]      win_start,
  output logic [CNT_W-1:0]      irq_point
);

  localparam int unsigned NSEL = 1 << WDG_SEL_W;

  logic [CNT_W-1:0] lim_tab [NSEL];

  // one constant per select code, built from the exponent function
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(1) << period_exp(WDG_SEL_W'(g));
  end

  always_comb begin
    limit     = lim_tab[period_sel];
    irq_point = (limit >> 1) + (limit >> 2);
    case (win_sel_e'(window_sel))
      WIN_HALF: win_start = limit >> 1;
      WIN_3QTR: win_start = limit >> 2;
      default:  win_start = '0;
    endcase
  end

endmodule

// File: rtl/wdg_keycheck.sv
module wdg_keycheck
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 18,
  parameter logic [WDG_DATA_W-1:0] KEY = WDG_KEY
) (
  input  logic                  trig_we,
  input  logic [WDG_DATA_W-1:0] trig_data,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      win_start,
  output logic                  refresh_ok,
  output logic                  violation
);

  logic key_match;
  logic win_open;

  always_comb begin
    key_match  = (trig_data == KEY);
    win_open   = (cnt >= win_start);
    refresh_ok = trig_we & key_match & win_open;
    violation  = trig_we & ~refresh_ok;
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             standby_run,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic             refresh_ok,
  input  logic             violation,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] irq_point,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             intv_irq
);

  logic             paused;
  logic             paused_q;
  logic             wake;
  logic             advance;
  logic             overflow;
  logic             clear;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             rst_req_d;
  logic             irq_d;

  always_comb begin
    paused    = (halt_req | stop_req) & ~standby_run;
    wake      = paused_q & ~paused;
    advance   = tick_en & ~paused & ~wake;
    cnt_inc   = cnt + CNT_W'(1);
    overflow  = advance & ~refresh_ok & ~violation & (cnt >= limit - CNT_W'(1));
    clear     = wake | refresh_ok | violation | overflow;
    rst_req_d = violation | overflow;
    irq_d     = advance & ~clear & (cnt_inc == irq_point);
    if (clear)        cnt_d = '0;
    else if (advance) cnt_d = cnt_inc;
    else              cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      paused_q <= 1'b0;
      rst_req  <= 1'b0;
      intv_irq <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      paused_q <= paused;
      rst_req  <= rst_req_d;
      intv_irq <= irq_d;
    end
  end

  AST_RST_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0)); // R2

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !refresh_ok && !violation) |=> (cnt == $past(cnt))); // R4

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |=> (cnt == '0)); // R6

  AST_IRQ_AT_3QTR: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_irq && $stable(limit)) |-> (cnt == irq_point)); // R9

  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wake && !refresh_ok && !violation) |=> (cnt == $past(cnt))); // R11

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 18,
  parameter logic [7:0]  KEY   = WDG_KEY
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] period_sel,
  input  logic [1:0] window_sel,
  input  logic       standby_run,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       trig_we,
  input  logic [7:0] trig_data,
  output logic       rst_req,
  output logic       intv_irq
);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] win_start;
  logic [CNT_W-1:0] irq_point;
  logic [CNT_W-1:0] cnt;
  logic             refresh_ok;
  logic             violation;

  wdg_limits #(.CNT_W(CNT_W)) u_limits (
    .period_sel (period_sel),
    .window_sel (window_sel),
    .limit      (limit),
    .win_start  (win_start),
    .irq_point  (irq_point)
  );

  wdg_keycheck #(.CNT_W(CNT_W), .KEY(KEY)) u_keycheck (
    .trig_we    (trig_we),
    .trig_data  (trig_data),
    .cnt        (cnt),
    .win_start  (win_start),
    .refresh_ok (refresh_ok),
    .violation  (violation)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .standby_run (standby_run),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .refresh_ok  (refresh_ok),
    .violation   (violation),
    .limit       (limit),
    .irq_point   (irq_point),
    .cnt         (cnt),
    .rst_req     (rst_req),
    .intv_irq    (intv_irq)
  );

  AST_BAD_KEY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data != KEY) |=> rst_req); // R7

  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> (!rst_req && cnt == '0)); // R10

  AST_EARLY_KEY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data == KEY && cnt < win_start) |=> rst_req); // R8

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [2:0] period_sel;
  logic [1:0] window_sel;
  logic       standby_run;
  logic       halt_req;
  logic       stop_req;
  logic       trig_we;
  logic [7:0] trig_data;
  logic       rst_req;
  logic       intv_irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R2";
  int tick_div = 1;
  int tick_ph = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_sel(period_sel),
    .window_sel(window_sel), .standby_run(standby_run), .halt_req(halt_req),
    .stop_req(stop_req), .trig_we(trig_we), .trig_data(trig_data),
    .rst_req(rst_req), .intv_irq(intv_irq)
  );

  // behavioural reference model
  longint m_cnt;
  bit m_pq, exp_rst, exp_irq;

  function automatic longint ovf_count(input logic [2:0] s);
    case (s)
      3'd0: return 128;    3'd1: return 256;
      3'd2: return 512;    3'd3: return 1024;
      3'd4: return 4096;   3'd5: return 16384;
      3'd6: return 32768;  default: return 131072;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    longint lim, ws;
    bit paused, wake, ok, bad, adv, ovf;
    if (!rst_n) begin
      m_cnt = 0; m_pq = 0; exp_rst = 0; exp_irq = 0;
    end else begin
      lim = ovf_count(period_sel);
      ws = (window_sel == 2'd0) ? lim / 2 : (window_sel == 2'd1) ? lim / 4 : 0;
      paused = (halt_req || stop_req) && !standby_run;
      wake = m_pq && !paused;
      ok = trig_we && trig_data == 8'hAC && m_cnt >= ws;
      bad = trig_we && !ok;
      adv = tick_en && !paused && !wake;
      ovf = adv && !ok && !bad && (m_cnt + 1 >= lim);
      exp_irq = adv && !ok && !bad && !ovf && (m_cnt + 1 == lim * 3 / 4);
      exp_rst = bad || ovf;
      if (wake || ok || bad || ovf) m_cnt = 0;
      else if (adv) m_cnt = m_cnt + 1;
      m_pq = paused;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rst_req !== exp_rst || intv_irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s per-cycle actual rst=%b irq=%b expected rst=%b irq=%b",
               cur_req, rst_req, intv_irq, exp_rst, exp_irq);
    end
    tick_ph = (tick_ph + 1) % tick_div;
    tick_en = (tick_ph == 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig_we = 0; trig_data = 0; halt_req = 0; stop_req = 0;
    tick_ph = 0; tick_en = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_key(input logic [7:0] d);
    trig_we = 1'b1; trig_data = d;
    step();
    trig_we = 1'b0;
  endtask

  // step until a reset request; report cycles, ticks and irq cycle
  task automatic run_to_rst(input int max, output int n, output int ticks, output int irq_at);
    n = 0; ticks = 0; irq_at = -1;
    for (int i = 0; i < max; i++) begin
      if (tick_en) ticks++;
      step(); n++;
      if (intv_irq) irq_at = n;
      if (rst_req) break;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n, t, q;
    bit seen;
    period_sel = 3'd0; window_sel = 2'd0; standby_run = 1'b0;
    halt_req = 0; stop_req = 0; trig_we = 0; trig_data = 0; tick_en = 1;
    rst_n = 1'b0;
    @(negedge clk);
    cur_req = "R2";
    check(rst_req === 1'b0 && intv_irq === 1'b0, "R2 reset state", rst_req, 0);
    do_reset();

    // R1, R2, R9: overflow and interval point for the short periods
    for (int s = 0; s < 6; s++) begin
      cur_req = "R1";
      period_sel = 3'(s);
      do_reset();
      run_to_rst(20000, n, t, q);
      check(n == ovf_count(3'(s)), "R1 overflow cycles", n, ovf_count(3'(s)));
      check(q == ovf_count(3'(s)) * 3 / 4, "R9 interval pulse cycle", q, ovf_count(3'(s)) * 3 / 4);
      step();
      check(rst_req === 1'b0, "R2 single-cycle pulse", rst_req, 0);
    end

    // R2: count restarts from zero after overflow
    cur_req = "R2";
    period_sel = 3'd0; do_reset();
    run_to_rst(1000, n, t, q);
    run_to_rst(1000, n, t, q);
    check(n == 128, "R2 restart after overflow", n, 128);

    // R8: half window boundaries
    cur_req = "R8";
    window_sel = 2'd0;
    do_reset(); steps(63); write_key(8'hAC);
    check(rst_req === 1'b1, "R8 key before half window", rst_req, 1);
    do_reset(); steps(64); write_key(8'hAC);
    check(rst_req === 1'b0, "R8 key at half window start", rst_req, 0);
    // R8: 75% window
    window_sel = 2'd1;
    do_reset(); steps(31); write_key(8'hAC);
    check(rst_req === 1'b1, "R8 key before 75% window", rst_req, 1);
    do_reset(); steps(32); write_key(8'hAC);
    check(rst_req === 1'b0, "R8 key at 75% window start", rst_req, 0);
    // R8: full window
    window_sel = 2'd2;
    do_reset(); write_key(8'hAC);
    check(rst_req === 1'b0, "R8 key at count zero with full window", rst_req, 0);

    // R3: valid refresh clears the count
    cur_req = "R3";
    window_sel = 2'd0;
    do_reset(); steps(100); write_key(8'hAC);
    check(rst_req === 1'b0, "R3 no reset after refresh", rst_req, 0);
    run_to_rst(1000, n, t, q);
    check(n == 128, "R3 full period after refresh", n, 128);

    // R7: wrong key inside open window
    cur_req = "R7";
    do_reset(); steps(100); write_key(8'h55);
    check(rst_req === 1'b1, "R7 wrong key", rst_req, 1);
    run_to_rst(1000, n, t, q);
    check(n == 128, "R7 count cleared by violation", n, 128);

    // R10: refresh on the overflowing edge
    cur_req = "R10";
    do_reset(); steps(127); write_key(8'hAC);
    check(rst_req === 1'b0, "R10 refresh beats overflow", rst_req, 0);
    run_to_rst(1000, n, t, q);
    check(n == 128, "R10 full period after collision", n, 128);

    // R4 and R6: freeze then wake clear
    cur_req = "R4";
    standby_run = 1'b0;
    do_reset(); steps(50);
    halt_req = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin step(); if (rst_req) seen = 1; end
    check(seen == 0, "R4 halt freezes count", seen, 0);
    stop_req = 1'b1; halt_req = 1'b0;
    for (int i = 0; i < 300; i++) begin step(); if (rst_req) seen = 1; end
    check(seen == 0, "R4 stop freezes count", seen, 0);
    cur_req = "R6";
    stop_req = 1'b0;
    run_to_rst(1000, n, t, q);
    check(n == 129, "R6 wake clears then restarts", n, 129);

    // R5: standby_run keeps counting
    cur_req = "R5";
    standby_run = 1'b1;
    do_reset(); stop_req = 1'b1; halt_req = 1'b1;
    run_to_rst(1000, n, t, q);
    check(n == 128, "R5 counting continues in standby", n, 128);
    halt_req = 0; stop_req = 0; standby_run = 0;

    // R11: sparse ticks
    cur_req = "R11";
    tick_div = 3;
    do_reset();
    run_to_rst(2000, n, t, q);
    check(t == 128, "R11 ticks to overflow", t, 128);
    check(n > 300, "R11 idle cycles do not count", n, 384);
    tick_div = 1;

    // R1: long periods via half-window boundary
    cur_req = "R1";
    window_sel = 2'd0; period_sel = 3'd6;
    do_reset(); steps(16383); write_key(8'hAC);
    check(rst_req === 1'b1, "R1 sel6 window closed at 16383", rst_req, 1);
    do_reset(); steps(16384); write_key(8'hAC);
    check(rst_req === 1'b0, "R1 sel6 window open at 16384", rst_req, 0);
    period_sel = 3'd7;
    do_reset(); steps(65536); write_key(8'hAC);
    check(rst_req === 1'b0, "R1 sel7 window open at 65536", rst_req, 0);

    finish_run();
  end

endmodule